// File: doc/BRIEF.md
# Program Interruption Priority Resolver

This block sits at the end of a processor's exception-detection logic. Each instruction leaves execution with a vector of program-interruption condition flags. The block reduces that vector to the single cause the interruption logic must report, using a fixed ranking. Conditions that the architecture treats as mutually exclusive share one tier. When several flags in such a tier are raised together anyway, the lowest-indexed flag wins, and a clash indicator goes out with the cause.

The block also keeps one bit of state across instructions. An instruction that loads a new status word (a full load, a system-mask set, or a system-mask OR) can leave a one in a reserved bit of that word. That fault is not charged to the instruction that caused it. It is held, and then reported against the next instruction ahead of anything that instruction raised. It is held only if the introducing instruction raised no exception of its own.

Instructions arrive on a valid/ready stream, and resolved causes leave on a valid/ready stream through a single output register. An input is accepted when `in_valid && in_ready`, and `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds still and no input is taken.

Top module: `prog_int_resolver`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0, `in_ready` is 1 and any held status-word fault is discarded, so an accepted instruction with no flags then produces no output.
- R2: Flag bit i of `in_cond` has cause code i, and a lower index means a higher priority. The bits are: 0 reserved status-word bit; 1 odd instruction address; 2 and 3 access on the first and second halfword of an execute-type instruction; 4 execute target misaligned; 5, 6 and 7 instruction fetch on halfwords one, two and three; 8 to 11 operation, privileged, execute and special-operation; 12 other specification; 13 to 17 operand access, data, decimal divide, page state and page transition; 18 to 20 fixed-point divide, floating-point divide and other completing conditions. The reported cause is the lowest set index.
- R3: Bits 8 to 11, 13 to 17 and 18 to 20 each form an exclusive tier. `out_clash` is 1 exactly when the winning cause lies in such a tier and two or more of that tier's bits were set. Otherwise it is 0.
- R4: An accepted instruction with no flags raised and no held fault produces no output (`out_valid` stays 0).
- R5: An accepted instruction with `in_psw_set`=1 and no flags raised stores a held fault. The next accepted instruction reports cause 0 with `out_clash`=0, whatever its own flags are.
- R6: `in_psw_set` has no effect when the same instruction raised any flag.
- R7: A held fault is cleared once it is reported, so the instruction after it is resolved from its own flags only.
- R8: The result of an instruction accepted at a clock edge is on the outputs right after that edge. When `out_ready` is 1 and no new input is accepted, `out_valid` drops after one cycle.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_cause` and `out_clash` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction condition vector is offered |
| in_ready | output | 1 | Block can accept an instruction |
| in_cond | input | 21 | Condition flags, bit i is cause i |
| in_psw_set | input | 1 | Instruction introduced a status-word reserved-bit error |
| out_valid | output | 1 | A resolved cause is present |
| out_ready | input | 1 | Consumer takes the resolved cause |
| out_cause | output | 5 | Resolved cause code |
| out_clash | output | 1 | Exclusive tier had multiple flags raised |

## Verification
The only hidden state is the held status-word fault, and any error in it is visible on the very next accepted instruction. A fault that is set when it should not be shows up as a spurious cause 0, or as an output where none is due. A fault that is lost shows up as that instruction's own cause in place of 0. Ranking or tier mistakes appear in the output register one cycle after the instruction is accepted. A fault in the register's hold logic shows up as a changed cause or a dropped `out_valid` during a stall.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam int NCOND = 21;
  localparam int CW    = $clog2(NCOND);
  localparam int NGRP  = 3;
  // exclusive tiers: inclusive index ranges
  localparam int GRP_LO [NGRP] = '{8, 13, 18};
  localparam int GRP_HI [NGRP] = '{11, 17, 20};

  typedef enum logic [CW-1:0] {
    CAUSE_PSW_BIT, CAUSE_ODD_IA, CAUSE_EXA1, CAUSE_EXA2, CAUSE_EX_ALIGN,
    CAUSE_IFA1, CAUSE_IFA2, CAUSE_IFA3, CAUSE_OPER, CAUSE_PRIV, CAUSE_EXEC,
    CAUSE_SPOP, CAUSE_SPEC, CAUSE_OPND, CAUSE_DATA, CAUSE_DDIV, CAUSE_PGST,
    CAUSE_PGTR, CAUSE_FXDIV, CAUSE_FPDIV, CAUSE_COMPL
  } cause_e;
endpackage

// File: rtl/pir_pick.sv
module pir_pick #(
  parameter int N = 21,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/pir_clash.sv
module pir_clash
  import pir_pkg::*;
(
  input  logic [NCOND-1:0] cond,
  input  logic [CW-1:0]    win,
  output logic             clash
);
  logic [NGRP-1:0] in_grp;
  logic [NGRP-1:0] multi;

  for (genvar g = 0; g < NGRP; g++) begin : g_tier
    localparam int LO = GRP_LO[g];
    localparam int HI = GRP_HI[g];
    assign in_grp[g] = (win >= CW'(LO)) && (win <= CW'(HI));
    assign multi[g]  = $countones(cond[HI:LO]) > 1;
  end

  assign clash = |(in_grp & multi);
endmodule

// File: rtl/pir_defer.sv
module pir_defer (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic psw_set,
  input  logic any_cond,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst)
      pend <= 1'b0;
    else if (accept)
      pend <= pend ? 1'b0 : (psw_set && !any_cond);
  end
endmodule

// File: rtl/prog_int_resolver.sv
module prog_int_resolver
  import pir_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NCOND-1:0] in_cond,
  input  logic             in_psw_set,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CW-1:0]    out_cause,
  output logic             out_clash
);
  logic          accept;
  logic          any_cond;
  logic [CW-1:0] win_idx;
  logic          tier_clash;
  logic          pend;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  pir_pick #(.N(NCOND), .W(CW)) u_pick (
    .req (in_cond),
    .any (any_cond),
    .idx (win_idx)
  );

  pir_clash u_clash (
    .cond  (in_cond),
    .win   (win_idx),
    .clash (tier_clash)
  );

  pir_defer u_defer (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .psw_set  (in_psw_set),
    .any_cond (any_cond),
    .pend     (pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_cause <= '0;
      out_clash <= 1'b0;
    end else if (accept) begin
      out_valid <= pend || any_cond;
      out_cause <= pend ? CAUSE_PSW_BIT : win_idx;
      out_clash <= pend ? 1'b0 : tier_clash;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/prog_int_resolver_chk.sv
module prog_int_resolver_chk
  import pir_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [NCOND-1:0] in_cond,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CW-1:0]    out_cause,
  input logic             out_clash,
  input logic             pend
);
  logic             acc;
  logic [NCOND-1:0] below_mask;
  assign acc        = in_valid && in_ready;
  assign below_mask = (NCOND'(1) << out_cause) - NCOND'(1);

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && !pend); // R1
  AST_WINNER_LOWEST: assert property (@(posedge clk) disable iff (rst)
    acc && !pend && (in_cond != '0) |=>
      out_valid && (($past(in_cond) & below_mask) == '0) &&
      ((($past(in_cond) >> out_cause) & NCOND'(1)) != '0)); // R2
  AST_NO_FLAG_NO_OUT: assert property (@(posedge clk) disable iff (rst)
    acc && !pend && (in_cond == '0) |=> !out_valid); // R4
  AST_DEFER_REPORT: assert property (@(posedge clk) disable iff (rst)
    acc && pend |=> out_valid && (out_cause == '0) && !out_clash); // R5
  AST_FLAGGED_NO_DEFER: assert property (@(posedge clk) disable iff (rst)
    acc && !pend && (in_cond != '0) |=> !pend); // R6
  AST_DEFER_CLEARS: assert property (@(posedge clk) disable iff (rst)
    acc && pend |=> !pend); // R7
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_cause) && $stable(out_clash)); // R9
endmodule

bind prog_int_resolver prog_int_resolver_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_cond(in_cond), .out_valid(out_valid), .out_ready(out_ready),
  .out_cause(out_cause), .out_clash(out_clash), .pend(pend)
);

// File: tb/prog_int_resolver_test.sv
module prog_int_resolver_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [20:0] in_cond = '0;
  logic        in_psw_set = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [4:0]  out_cause;
  logic        out_clash;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_int_resolver uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_cond(in_cond), .in_psw_set(in_psw_set), .out_valid(out_valid),
    .out_ready(out_ready), .out_cause(out_cause), .out_clash(out_clash)
  );

  // {cond[21], psw_set, exp_valid, exp_cause[5], exp_clash, req[4]}
  localparam logic [32:0] TBL [NV] = '{
    {21'h000000, 1'b0, 1'b0, 5'd0,  1'b0, 4'd4}, // R4 nothing raised
    {21'h002020, 1'b0, 1'b1, 5'd5,  1'b0, 4'd2}, // R2
    {21'h100002, 1'b0, 1'b1, 5'd1,  1'b0, 4'd2}, // R2
    {21'h000600, 1'b0, 1'b1, 5'd9,  1'b1, 4'd3}, // R3 clash
    {21'h00D000, 1'b0, 1'b1, 5'd12, 1'b0, 4'd2}, // R2
    {21'h000000, 1'b1, 1'b0, 5'd0,  1'b0, 4'd5}, // R5 store fault
    {21'h000104, 1'b0, 1'b1, 5'd0,  1'b0, 4'd5}, // R5 fault wins
    {21'h000104, 1'b0, 1'b1, 5'd2,  1'b0, 4'd7}, // R7 cleared
    {21'h080000, 1'b1, 1'b1, 5'd19, 1'b0, 4'd6}, // R6
    {21'h010000, 1'b0, 1'b1, 5'd16, 1'b0, 4'd6}, // R6 no fault held
    {21'h022000, 1'b0, 1'b1, 5'd13, 1'b1, 4'd3}, // R3
    {21'h000098, 1'b0, 1'b1, 5'd3,  1'b0, 4'd2}, // R2
    {21'h000003, 1'b0, 1'b1, 5'd0,  1'b0, 4'd2}, // R2
    {21'h000000, 1'b1, 1'b0, 5'd0,  1'b0, 4'd5}, // R5
    {21'h000000, 1'b0, 1'b1, 5'd0,  1'b0, 4'd5}, // R5 reported with no own flag
    {21'h000000, 1'b0, 1'b0, 5'd0,  1'b0, 4'd7}, // R7
    {21'h140000, 1'b0, 1'b1, 5'd18, 1'b1, 4'd3}, // R3
    {21'h000800, 1'b0, 1'b1, 5'd11, 1'b0, 4'd3}, // R3 single in tier
    {21'h000240, 1'b0, 1'b1, 5'd6,  1'b0, 4'd2}, // R2
    {21'h000001, 1'b1, 1'b1, 5'd0,  1'b0, 4'd6}, // R6
    {21'h000000, 1'b0, 1'b0, 5'd0,  1'b0, 4'd6}  // R6 nothing held
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // from negedge: drive, pass one rising edge, return at next negedge
  task automatic step(input logic [20:0] c, input logic ps);
    in_valid   = 1'b1;
    in_cond    = c;
    in_psw_set = ps;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int ref_low(input logic [20:0] c);
    for (int i = 0; i < 21; i++) if (c[i]) return i;
    return 0;
  endfunction

  function automatic logic ref_clash(input logic [20:0] c);
    int w = ref_low(c);
    if (w >= 8 && w <= 11)  return $countones(c[11:8]) > 1;
    if (w >= 13 && w <= 17) return $countones(c[17:13]) > 1;
    if (w >= 18)            return $countones(c[20:18]) > 1;
    return 1'b0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic rpend;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R1 in_ready after reset", int'(in_ready), 1);

    for (int k = 0; k < NV; k++) begin
      logic [32:0] e = TBL[k];
      step(e[32:12], e[11]);
      chk($sformatf("R%0d row %0d valid", e[3:0], k), int'(out_valid), int'(e[10]));
      if (e[10]) begin
        chk($sformatf("R%0d row %0d cause", e[3:0], k), int'(out_cause), int'(e[9:5]));
        chk($sformatf("R%0d row %0d clash", e[3:0], k), int'(out_clash), int'(e[4]));
      end
    end

    // R9 back-pressure
    out_ready = 1'b0;
    step(21'h000080, 1'b0);
    chk("R8 valid after accept", int'(out_valid), 1);
    chk("R8 cause after accept", int'(out_cause), 7);
    chk("R9 in_ready low while stalled", int'(in_ready), 0);
    step(21'h000002, 1'b0);
    step(21'h000002, 1'b0);
    chk("R9 valid held", int'(out_valid), 1);
    chk("R9 cause held", int'(out_cause), 7);
    out_ready = 1'b1;
    step(21'h000002, 1'b0);
    chk("R9 held input taken on release", int'(out_cause), 1);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R8 one-cycle pulse", int'(out_valid), 0);

    // R1 reset discards held fault
    step(21'h000000, 1'b1);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 out_valid after mid reset", int'(out_valid), 0);
    step(21'h000000, 1'b0);
    chk("R1 held fault dropped", int'(out_valid), 0);

    // random multi-hot vectors against a reference ranking
    rpend = 1'b0;
    for (int n = 0; n < 400; n++) begin
      logic [20:0] c = 21'($urandom & $urandom & $urandom);
      logic ps = ($urandom % 3) == 0;
      logic ev;
      if (($urandom % 4) == 0) c = '0;
      step(c, ps);
      ev = rpend || (c != '0);
      chk("R4 random valid", int'(out_valid), int'(ev));
      if (ev) begin
        chk("R2 random cause", int'(out_cause), rpend ? 0 : ref_low(c));
        chk("R3 random clash", int'(out_clash), rpend ? 0 : int'(ref_clash(c)));
      end
      rpend = rpend ? 1'b0 : (ps && (c == '0));
    end
    in_valid = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule